// File: doc/BRIEF.md
# Sector Cache with Per-Subsector Valid Tracking

This read-only cache holds a few large sectors. Each sector carries one address tag, and its storage is split into subsectors, one data word each. A sector is bound to a region of backing storage when a lookup misses on every sector tag. After that, its subsectors are fetched one at a time, only when a read touches them. Every subsector has its own valid flag, so a sector can be partly filled.

A read can therefore end in one of three ways:
- **Hit:** a sector tag matches and the subsector's flag is set, so the word comes from local storage.
- **Subsector miss:** the tag matches but the flag is clear, so only that word is fetched into the sector already assigned.
- **Sector miss:** no tag matches. A sector is claimed, its flags are wiped, and the one subsector asked for is fetched.

A sector is claimed from the unallocated sectors first, then from the sector least recently used.

Reads enter on a valid/ready request channel and leave on a valid/ready response channel. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. A response transfers on an edge where `rsp_valid` and `rsp_ready` are both high. Until then, the response word waits in its register with no limit on the stall.

Backing storage is reached through a request channel and a response pulse:
- The request channel (`mem_req_valid`/`mem_req_ready`) carries a word-aligned address.
- One `mem_rsp_valid` pulse returns the word. This side has no back-pressure, because the cache always waits for it.

Only one read is handled at a time.

Top module: `subsector_cache`

## Requirements
- R1: A read that hits is answered with `rsp_valid` high in the cycle after the request is taken. The stored word is on `rsp_data`, and no backing request is raised.
- R2: A read whose tag matches no allocated sector claims a sector and raises exactly one backing request. That request's address is the read address with its two low (byte offset) bits forced to zero. The response returns the word from `mem_rsp_data`.
- R3: A read whose sector tag matches but whose subsector is not yet valid raises exactly one backing request. Afterwards, both the new subsector and the subsectors filled before it hit in that sector.
- R4: Claiming a sector invalidates every subsector of it. Only the fetched subsector becomes valid, so a later read of another subsector in that sector raises a backing request.
- R5: Replacement picks the lowest-numbered unallocated sector first. Once all sectors are allocated, it picks the sector least recently hit or filled. A read of the evicted region then misses again.
- R6: `req_ready` is high only when no read is in progress. It stays low from the edge that takes a read until the edge that delivers its response.
- R7: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` stays high and `rsp_data` does not change.
- R8: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays raised with a stable address. After acceptance, the cache waits for `mem_rsp_valid`.
- R9: After reset, `req_ready` is high and `rsp_valid` and `mem_req_valid` are low. No sector is allocated, so the first read misses.
- R10: The byte-offset bits of `req_addr` (bits [1:0]) take no part in the lookup. Two reads that differ only there return the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Cache can take a read |
| req_addr | input | 32 | Byte address of the read |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Consumer takes the read data |
| rsp_data | output | 32 | Read data word |
| mem_req_valid | output | 1 | Backing fetch request present |
| mem_req_ready | input | 1 | Backing store takes the fetch |
| mem_req_addr | output | 32 | Word-aligned fetch address |
| mem_rsp_valid | input | 1 | One-cycle pulse carrying fetched word |
| mem_rsp_data | input | 32 | Fetched word |

## Verification
The hardest state to reach is a full cache whose recency order is not simply the allocation order, followed by a sector miss that must evict one particular partly filled sector. The stimulus draws sector tags from a pool only a little larger than the sector count, so sector misses keep evicting. Subsector indices are drawn at random, which mixes subsector misses with hits on older sectors. The backing-store and response stalls are random, so each handshake is also seen under back-pressure. A directed prologue first walks through a forced eviction by hand.

// File: rtl/sc_pkg.sv
package sc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_MREQ  = 2'd1,
    ST_MWAIT = 2'd2,
    ST_RESP  = 2'd3
  } sc_state_e;
endpackage

// File: rtl/sc_directory.sv
module sc_directory #(
  parameter int SECTORS = 4,
  parameter int SUBS    = 8,
  parameter int TAG_W   = 27,
  parameter int IDX_W   = 3,
  parameter int WAY_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [TAG_W-1:0]   look_tag,
  input  logic [IDX_W-1:0]   look_idx,
  input  logic               alloc_en,
  input  logic [WAY_W-1:0]   alloc_way,
  input  logic [TAG_W-1:0]   alloc_tag,
  input  logic               fill_en,
  input  logic [WAY_W-1:0]   fill_way,
  input  logic [IDX_W-1:0]   fill_idx,
  output logic               tag_hit,
  output logic               sub_hit,
  output logic [WAY_W-1:0]   hit_way,
  output logic [SECTORS-1:0] free_vec
);
  logic [TAG_W-1:0]   tag_q   [SECTORS];
  logic [SUBS-1:0]    valid_q [SECTORS];
  logic [SECTORS-1:0] alloc_q;
  logic [SECTORS-1:0] match_vec;

  // parallel tag compare across all sectors
  for (genvar g = 0; g < SECTORS; g++) begin : g_cmp
    assign match_vec[g] = alloc_q[g] && (tag_q[g] == look_tag);
  end

  always_comb begin
    hit_way = '0;
    for (int i = 0; i < SECTORS; i++)
      if (match_vec[i]) hit_way = hit_way | WAY_W'(i);
  end

  assign tag_hit  = |match_vec;
  assign sub_hit  = tag_hit && valid_q[hit_way][look_idx];
  assign free_vec = ~alloc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alloc_q <= '0;
      for (int i = 0; i < SECTORS; i++) begin
        tag_q[i]   <= '0;
        valid_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < SECTORS; i++) begin
        if (alloc_en && alloc_way == WAY_W'(i)) begin
          alloc_q[i] <= 1'b1;
          tag_q[i]   <= alloc_tag;
          valid_q[i] <= '0;
        end else if (fill_en && fill_way == WAY_W'(i)) begin
          valid_q[i][fill_idx] <= 1'b1;
        end
      end
    end
  end

  // R2
  tag_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));

  // R4
  alloc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |=> (valid_q[$past(alloc_way)] == '0));

  // R3
  fill_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> valid_q[$past(fill_way)][$past(fill_idx)]);
endmodule

// File: rtl/sc_lru.sv
module sc_lru #(
  parameter int SECTORS = 4,
  parameter int WAY_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               touch_en,
  input  logic [WAY_W-1:0]   touch_way,
  input  logic [SECTORS-1:0] free_vec,
  output logic [WAY_W-1:0]   victim_way
);
  // newer_q[i][j] set: sector i was used more recently than sector j
  logic [SECTORS-1:0] newer_q [SECTORS];
  logic [SECTORS-1:0] oldest_vec;

  for (genvar g = 0; g < SECTORS; g++) begin : g_old
    assign oldest_vec[g] = (newer_q[g] & ~(SECTORS'(1) << g)) == '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SECTORS; i++)
        for (int j = 0; j < SECTORS; j++)
          newer_q[i][j] <= (i > j);
    end else if (touch_en) begin
      for (int i = 0; i < SECTORS; i++)
        for (int j = 0; j < SECTORS; j++)
          if (i != j) begin
            if (touch_way == WAY_W'(i)) newer_q[i][j] <= 1'b1;
            else if (touch_way == WAY_W'(j)) newer_q[i][j] <= 1'b0;
          end
    end
  end

  always_comb begin
    logic picked;
    victim_way = '0;
    picked     = 1'b0;
    for (int i = 0; i < SECTORS; i++)
      if (free_vec[i] && !picked) begin
        victim_way = WAY_W'(i);
        picked     = 1'b1;
      end
    for (int i = 0; i < SECTORS; i++)
      if (oldest_vec[i] && !picked) begin
        victim_way = WAY_W'(i);
        picked     = 1'b1;
      end
  end

  // R5
  lru_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(oldest_vec) == 1);

  // R5
  touch_newest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> !oldest_vec[$past(touch_way)]);
endmodule

// File: rtl/sc_data_store.sv
module sc_data_store #(
  parameter int SECTORS = 4,
  parameter int SUBS    = 8,
  parameter int DATA_W  = 32,
  parameter int WAY_W   = 2,
  parameter int IDX_W   = 3
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [WAY_W-1:0]  wr_way,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [WAY_W-1:0]  rd_way,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = SECTORS * SUBS;

  logic [DATA_W-1:0] word_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) word_q[{wr_way, wr_idx}] <= wr_data;
  end

  assign rd_data = word_q[{rd_way, rd_idx}];
endmodule

// File: rtl/subsector_cache.sv
module subsector_cache
  import sc_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int SECTORS = 4,
  parameter int SUBS    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data
);
  localparam int OFF_W = $clog2(DATA_W / 8);
  localparam int IDX_W = $clog2(SUBS);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
  localparam int WAY_W = $clog2(SECTORS);

  sc_state_e         state_q;
  logic [TAG_W-1:0]  pend_tag_q;
  logic [IDX_W-1:0]  pend_idx_q;
  logic [WAY_W-1:0]  pend_way_q;
  logic [DATA_W-1:0] rsp_data_q;

  logic [TAG_W-1:0]   look_tag;
  logic [IDX_W-1:0]   look_idx;
  logic               unused_off;
  logic               tag_hit, sub_hit;
  logic [WAY_W-1:0]   hit_way, victim_way, touch_way;
  logic [SECTORS-1:0] free_vec;
  logic [DATA_W-1:0]  rd_data;
  logic               take, alloc_en, fill_en, touch_en;

  assign look_tag   = req_addr[ADDR_W-1 -: TAG_W];
  assign look_idx   = req_addr[OFF_W +: IDX_W];
  assign unused_off = ^req_addr[OFF_W-1:0];

  assign req_ready     = (state_q == ST_IDLE);
  assign rsp_valid     = (state_q == ST_RESP);
  assign rsp_data      = rsp_data_q;
  assign mem_req_valid = (state_q == ST_MREQ);
  assign mem_req_addr  = {pend_tag_q, pend_idx_q, {OFF_W{1'b0}}};

  assign take      = req_valid && req_ready;
  assign alloc_en  = take && !tag_hit;
  assign fill_en   = (state_q == ST_MWAIT) && mem_rsp_valid;
  assign touch_en  = (take && sub_hit) || fill_en;
  assign touch_way = fill_en ? pend_way_q : hit_way;

  sc_directory #(
    .SECTORS(SECTORS), .SUBS(SUBS), .TAG_W(TAG_W), .IDX_W(IDX_W), .WAY_W(WAY_W)
  ) u_dir (
    .clk(clk), .rst_n(rst_n),
    .look_tag(look_tag), .look_idx(look_idx),
    .alloc_en(alloc_en), .alloc_way(victim_way), .alloc_tag(look_tag),
    .fill_en(fill_en), .fill_way(pend_way_q), .fill_idx(pend_idx_q),
    .tag_hit(tag_hit), .sub_hit(sub_hit), .hit_way(hit_way), .free_vec(free_vec)
  );

  sc_lru #(.SECTORS(SECTORS), .WAY_W(WAY_W)) u_lru (
    .clk(clk), .rst_n(rst_n),
    .touch_en(touch_en), .touch_way(touch_way),
    .free_vec(free_vec), .victim_way(victim_way)
  );

  sc_data_store #(
    .SECTORS(SECTORS), .SUBS(SUBS), .DATA_W(DATA_W), .WAY_W(WAY_W), .IDX_W(IDX_W)
  ) u_data (
    .clk(clk),
    .wr_en(fill_en), .wr_way(pend_way_q), .wr_idx(pend_idx_q), .wr_data(mem_rsp_data),
    .rd_way(hit_way), .rd_idx(look_idx), .rd_data(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      pend_tag_q <= '0;
      pend_idx_q <= '0;
      pend_way_q <= '0;
      rsp_data_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (take) begin
          if (sub_hit) begin
            rsp_data_q <= rd_data;
            state_q    <= ST_RESP;
          end else begin
            pend_tag_q <= look_tag;
            pend_idx_q <= look_idx;
            pend_way_q <= tag_hit ? hit_way : victim_way;
            state_q    <= ST_MREQ;
          end
        end
        ST_MREQ:  if (mem_req_ready) state_q <= ST_MWAIT;
        ST_MWAIT: if (mem_rsp_valid) begin
          rsp_data_q <= mem_rsp_data;
          state_q    <= ST_RESP;
        end
        ST_RESP:  if (rsp_ready) state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  // R1
  hit_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && sub_hit) |=> (rsp_valid && !mem_req_valid));

  // R6
  busy_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !sub_hit) |=> (!req_ready && mem_req_valid));

  // R7
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  // R8
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
endmodule

// File: tb/subsector_cache_test.sv
`timescale 1ns/1ps
module subsector_cache_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [31:0] req_addr = '0;
  logic        rsp_valid, rsp_ready = 1'b0;
  logic [31:0] rsp_data;
  logic        mem_req_valid, mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;

  int errors = 0, checks = 0, mem_count = 0;
  logic [31:0] last_addr = '0;
  bit done = 0;

  always #4 clk = ~clk;

  subsector_cache uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  function automatic logic [31:0] mdata(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h00C3_A55A;
  endfunction

  function automatic logic [31:0] mk(input int tag, input int idx, input int off);
    return {27'(tag), 3'(idx), 2'(off)};
  endfunction

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // reference model
  logic [26:0] m_tag [4];
  bit          m_alloc [4];
  bit [7:0]    m_val [4];
  int          m_stamp [4];
  int          m_time = 0;

  task automatic model_access(input logic [31:0] a, output bit miss);
    int w = -1;
    int idx = int'(a[4:2]);
    for (int i = 0; i < 4; i++) if (m_alloc[i] && m_tag[i] == a[31:5]) w = i;
    if (w >= 0) begin
      miss = !m_val[w][idx];
    end else begin
      miss = 1;
      for (int i = 3; i >= 0; i--) if (!m_alloc[i]) w = i;
      if (w < 0) begin
        w = 0;
        for (int i = 1; i < 4; i++) if (m_stamp[i] < m_stamp[w]) w = i;
      end
      m_alloc[w] = 1; m_tag[w] = a[31:5]; m_val[w] = '0;
    end
    m_val[w][idx] = 1;
    m_time++;
    m_stamp[w] = m_time;
  endtask

  // backing store agent (R8)
  initial begin
    bit waiting = 0;
    logic [31:0] paddr = '0;
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    forever begin
      @(negedge clk);
      if (waiting)
        check(mem_req_valid === 1'b1 && mem_req_addr === paddr, "R8",
              "fetch held under stall", mem_req_addr, paddr);
      mem_req_ready = ($urandom % 2) == 0;
      if (mem_req_valid && mem_req_ready) begin
        waiting = 0;
        mem_count++;
        last_addr = mem_req_addr;
        @(negedge clk);
        mem_req_ready = 1'b0;
        repeat ($urandom % 3) @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mdata(last_addr);
        @(negedge clk);
        mem_rsp_valid = 1'b0;
      end else begin
        waiting = mem_req_valid;
        paddr   = mem_req_addr;
      end
    end
  end

  task automatic do_req(input logic [31:0] a, input string rq);
    bit exp_miss, held;
    logic [31:0] exp_data, hd, got;
    int mc0;
    model_access(a, exp_miss);
    exp_data = mdata({a[31:2], 2'b00});
    mc0 = mem_count;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (!exp_miss)
      check(rsp_valid === 1'b1, rq, "R1 hit answered next cycle", 32'(rsp_valid), 32'd1);
    held = 0; hd = '0; got = '0;
    forever begin
      if (held)
        check(rsp_valid === 1'b1 && rsp_data === hd, "R7", "response held", rsp_data, hd);
      check(req_ready === 1'b0, "R6", "busy during read", 32'(req_ready), 32'd0);
      rsp_ready = ($urandom % 3) != 0;
      if (rsp_valid && rsp_ready) begin
        got = rsp_data;
        @(negedge clk);
        rsp_ready = 1'b0;
        break;
      end
      held = rsp_valid; hd = rsp_data;
      @(negedge clk);
    end
    check(got === exp_data, rq, "read data", got, exp_data);
    check(mem_count - mc0 == int'(exp_miss), rq, "fetch count",
          32'(mem_count - mc0), 32'(exp_miss));
    if (exp_miss)
      check(last_addr === {a[31:2], 2'b00}, rq, "fetch address", last_addr, {a[31:2], 2'b00});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 4; i++) begin
      m_alloc[i] = 0; m_val[i] = '0; m_stamp[i] = 0; m_tag[i] = '0;
    end
    repeat (3) @(negedge clk);
    check(req_ready === 1'b1 && rsp_valid === 1'b0 && mem_req_valid === 1'b0,
          "R9", "reset outputs", {29'd0, req_ready, rsp_valid, mem_req_valid}, 32'h4);
    rst_n = 1'b1;
    // directed prologue
    do_req(mk(1, 2, 0), "R9");  // first read misses
    do_req(mk(1, 2, 3), "R10"); // other byte offset hits
    do_req(mk(1, 5, 1), "R3");  // subsector miss
    do_req(mk(1, 2, 1), "R3");  // earlier fill still hits
    do_req(mk(1, 6, 0), "R4");  // untouched subsector misses
    do_req(mk(2, 0, 0), "R2");
    do_req(mk(3, 0, 0), "R2");
    do_req(mk(4, 0, 0), "R2");
    do_req(mk(1, 5, 0), "R1");  // tag 1 becomes newest
    do_req(mk(5, 1, 0), "R5");  // evicts tag 2
    do_req(mk(2, 0, 0), "R5");  // tag 2 misses again, evicts tag 3
    do_req(mk(1, 2, 2), "R5");  // tag 1 still resident
    do_req(mk(3, 0, 0), "R5");  // tag 3 gone
    // random mix
    for (int n = 0; n < 400; n++) begin
      int t = 1 + ($urandom % 6);
      do_req(mk(t * 3 + 7, $urandom % 8, $urandom % 4), "R2");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule